// File: doc/BRIEF.md
# Region Protection and Translation Unit

This block checks and translates memory accesses without paging. The 4 GB address space is cut into eight 512 MB regions, and the top three bits of the virtual address pick one of eight region entries. Each entry holds a physical region number and a 4-bit attribute code. The attribute code gives the read, write and execute rights and a cache policy. The block returns the physical address and the page size. When the request's kind is not allowed, it returns a prohibited-access cause instead of a grant.

A fallback mode ignores the entries. In that mode every address maps to itself, and the attribute for each region is read from a packed 32-bit cache-attribute register, four bits per region. A single write port updates either one entry or the cache-attribute register. Lookups are purely combinational, so a core can issue one translation per cycle with no added latency.

Top module: `rgn_xlate_unit`

## Requirements
- R1: After reset, entry i maps virtual region i to physical region i with attribute code 2, and the cache-attribute register holds 2 in every 4-bit field. So every lookup right after reset, in either mode, is an identity mapping with read, write and execute rights and bypass caching.
- R2: In translation mode (fallbackMode=0) the region index is reqVaddr[31:29]. physAddr is {entry base, reqVaddr[28:0]} and pageLog2 is 29.
- R3: In translation mode the attribute codes decode as follows. 0 gives read and write with write-through. 1 gives read, write and execute with write-through. 2 gives read, write and execute with bypass. 3 gives execute only with write-back. 4 and 5 give read, write and execute with write-back. 14 gives read and write with isolate. Every other code gives no rights and cacheMode none.
- R4: In fallback mode, attribute code 5 gives no rights and cacheMode none. Every other code decodes as in R3.
- R5: In fallback mode (fallbackMode=1), physAddr equals reqVaddr and pageLog2 is 12. The attribute is cacheAttr bits [4*idx+3 : 4*idx], where idx = reqVaddr[31:29]. The entries have no effect on any output.
- R6: reqKind 0 (load) needs read, 1 (store) needs write and 2 (fetch) needs execute. reqKind 3 is never granted.
- R7: grant=1 exactly when the right needed by the kind is present, and then faultCause is 0. When grant=0, faultCause is 1 for a fetch, 3 for a store and 2 for a load or for reqKind 3.
- R8: A write with wrEn=1 and wrTarget=0 sets entry wrIdx to base wrData[6:4] and attribute wrData[3:0]. With wrTarget=1 it loads cacheAttr from wrData. The new value is seen by lookups from the cycle after the clock edge, and not in the cycle of the write.
- R9: rdOk, wrOk and exOk show the decoded rights whatever the kind. cacheMode is 0 none, 1 bypass, 2 write-through, 3 write-back, 4 isolate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fallbackMode | input | 1 | 1 selects identity mapping with attributes from cacheAttr |
| reqVaddr | input | 32 | Virtual address to look up |
| reqKind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| wrEn | input | 1 | Register write strobe |
| wrTarget | input | 1 | 0 writes an entry, 1 writes cacheAttr |
| wrIdx | input | 3 | Entry selected for writing |
| wrData | input | 32 | Write data |
| physAddr | output | 32 | Translated address |
| pageLog2 | output | 6 | Log2 of the reported page size |
| rdOk | output | 1 | Read right |
| wrOk | output | 1 | Write right |
| exOk | output | 1 | Execute right |
| cacheMode | output | 3 | Cache policy code |
| grant | output | 1 | Access allowed for the requested kind |
| faultCause | output | 2 | Prohibited cause, 0 when granted |

## Verification
The bench uses the default parameters: a 32-bit address, three region bits (eight entries) and a fallback page log2 of 12. With these values the bench can sweep all sixteen attribute codes in both modes, for every access kind. Eight entries are few enough that random writes often land on the region being looked up in the same cycle, which tests the next-cycle rule of R8. The 29-bit region offset lets the bench check that the upper bits are replaced while the lower bits pass through.

// File: rtl/rgn_xlate_pkg.sv
package rgn_xlate_pkg;

  typedef enum logic [2:0] {
    CM_NONE    = 3'd0,
    CM_BYPASS  = 3'd1,
    CM_WTHRU   = 3'd2,
    CM_WBACK   = 3'd3,
    CM_ISOLATE = 3'd4
  } cacheMode_e;

  typedef enum logic [1:0] {
    FC_NONE  = 2'd0,
    FC_FETCH = 2'd1,
    FC_LOAD  = 2'd2,
    FC_STORE = 2'd3
  } faultCause_e;

  typedef enum logic [1:0] {
    AK_LOAD  = 2'd0,
    AK_STORE = 2'd1,
    AK_FETCH = 2'd2,
    AK_RSVD  = 2'd3
  } accKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic entryWe;
    logic caWe;
    logic useFallback;
    logic chkRead;
    logic chkWrite;
    logic chkExec;
  } ctlStrb_t;

  typedef struct packed {
    logic       r;
    logic       w;
    logic       x;
    cacheMode_e cm;
  } rights_t;

  // attribute decode; code 5 loses its rights in fallback mode
  function automatic rights_t decodeAttr(input logic [3:0] attr, input logic fallback);
    rights_t d;
    d = '{r: 1'b0, w: 1'b0, x: 1'b0, cm: CM_NONE};
    case (attr)
      4'd0:  d = '{r: 1'b1, w: 1'b1, x: 1'b0, cm: CM_WTHRU};
      4'd1:  d = '{r: 1'b1, w: 1'b1, x: 1'b1, cm: CM_WTHRU};
      4'd2:  d = '{r: 1'b1, w: 1'b1, x: 1'b1, cm: CM_BYPASS};
      4'd3:  d = '{r: 1'b0, w: 1'b0, x: 1'b1, cm: CM_WBACK};
      4'd4:  d = '{r: 1'b1, w: 1'b1, x: 1'b1, cm: CM_WBACK};
      4'd5:  if (!fallback) d = '{r: 1'b1, w: 1'b1, x: 1'b1, cm: CM_WBACK};
      4'd14: d = '{r: 1'b1, w: 1'b1, x: 1'b0, cm: CM_ISOLATE};
      default: d = '{r: 1'b0, w: 1'b0, x: 1'b0, cm: CM_NONE};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rgn_xlate_ctrl.sv
module rgn_xlate_ctrl
  import rgn_xlate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fallbackMode,
  input  logic [1:0] reqKind,
  input  logic       wrEn,
  input  logic       wrTarget,
  output ctlStrb_t   strb
);

  always_comb begin
    strb             = '0;
    strb.entryWe     = wrEn && !wrTarget;
    strb.caWe        = wrEn && wrTarget;
    strb.useFallback = fallbackMode;
    case (accKind_e'(reqKind))
      AK_LOAD:  strb.chkRead  = 1'b1;
      AK_STORE: strb.chkWrite = 1'b1;
      AK_FETCH: strb.chkExec  = 1'b1;
      default:  ;
    endcase
  end

  // R6: at most one right is ever demanded, none for the reserved kind
  a_r6_one_check: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.chkRead, strb.chkWrite, strb.chkExec}));

  a_r6_rsvd_none: assert property (@(posedge clk) disable iff (!rstN)
    (reqKind == 2'd3) |-> !(strb.chkRead || strb.chkWrite || strb.chkExec));

  // R8: a write never targets both stores
  a_r8_single_target: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.entryWe && strb.caWe));

endmodule

// File: rtl/rgn_xlate_dp.sv
module rgn_xlate_dp
  import rgn_xlate_pkg::*;
#(
  parameter int ADDR_W             = 32,
  parameter int REGION_BITS        = 3,
  parameter int FALLBACK_PAGE_LOG2 = 12
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctlStrb_t                        strb,
  input  logic [ADDR_W-1:0]               reqVaddr,
  input  logic [REGION_BITS-1:0]          wrIdx,
  input  logic [(4<<REGION_BITS)-1:0]     wrData,
  output logic [ADDR_W-1:0]               physAddr,
  output logic [$clog2(ADDR_W+1)-1:0]     pageLog2,
  output logic                            rdOk,
  output logic                            wrOk,
  output logic                            exOk,
  output logic [2:0]                      cacheMode,
  output logic                            grant,
  output logic [1:0]                      faultCause
);

  localparam int ATTR_W      = 4;
  localparam int NUM_REGIONS = 1 << REGION_BITS;
  localparam int OFF_W       = ADDR_W - REGION_BITS;
  localparam int CA_W        = ATTR_W * NUM_REGIONS;
  localparam int PL_W        = $clog2(ADDR_W + 1);
  localparam logic [CA_W-1:0]   CA_RESET   = {NUM_REGIONS{4'h2}};
  localparam logic [ATTR_W-1:0] ATTR_RESET = 4'h2;

  logic [REGION_BITS-1:0] entBase [NUM_REGIONS];
  logic [ATTR_W-1:0]      entAttr [NUM_REGIONS];
  logic [CA_W-1:0]        caQ;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_entry
    logic [REGION_BITS-1:0] baseQ;
    logic [ATTR_W-1:0]      attrQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ <= REGION_BITS'(g);
        attrQ <= ATTR_RESET;
      end else if (strb.entryWe && wrIdx == REGION_BITS'(g)) begin
        baseQ <= wrData[ATTR_W +: REGION_BITS];
        attrQ <= wrData[ATTR_W-1:0];
      end
    end
    assign entBase[g] = baseQ;
    assign entAttr[g] = attrQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          caQ <= CA_RESET;
    else if (strb.caWe) caQ <= wrData;
  end

  logic [REGION_BITS-1:0] regionIdx;
  logic [ATTR_W-1:0]      selAttr;
  rights_t                rights;

  assign regionIdx = reqVaddr[ADDR_W-1 -: REGION_BITS];

  always_comb begin
    if (strb.useFallback) begin
      selAttr  = caQ[regionIdx*ATTR_W +: ATTR_W];
      physAddr = reqVaddr;
      pageLog2 = PL_W'(FALLBACK_PAGE_LOG2);
    end else begin
      selAttr  = entAttr[regionIdx];
      physAddr = {entBase[regionIdx], reqVaddr[OFF_W-1:0]};
      pageLog2 = PL_W'(OFF_W);
    end
    rights = decodeAttr(selAttr, strb.useFallback);
  end

  assign rdOk      = rights.r;
  assign wrOk      = rights.w;
  assign exOk      = rights.x;
  assign cacheMode = rights.cm;
  assign grant     = (strb.chkRead && rights.r) || (strb.chkWrite && rights.w) ||
                     (strb.chkExec && rights.x);

  always_comb begin
    if (grant)              faultCause = FC_NONE;
    else if (strb.chkExec)  faultCause = FC_FETCH;
    else if (strb.chkWrite) faultCause = FC_STORE;
    else                    faultCause = FC_LOAD;
  end

  // R8: an entry written last cycle is what a same-region lookup sees now
  a_r8_entry_next: assert property (@(posedge clk) disable iff (!rstN)
    strb.entryWe |=> (strb.useFallback || regionIdx != $past(wrIdx) ||
                      physAddr[ADDR_W-1 -: REGION_BITS] == $past(wrData[ATTR_W +: REGION_BITS])));

  // R5: fallback is an identity map
  a_r5_identity: assert property (@(posedge clk) disable iff (!rstN)
    strb.useFallback |-> physAddr == reqVaddr);

  // R2: region offset passes through untouched
  a_r2_offset_pass: assert property (@(posedge clk) disable iff (!rstN)
    !strb.useFallback |-> physAddr[OFF_W-1:0] == reqVaddr[OFF_W-1:0]);

  // R7: cause and grant agree
  a_r7_grant_clean: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> faultCause == FC_NONE);
  a_r7_deny_cause: assert property (@(posedge clk) disable iff (!rstN)
    !grant |-> faultCause != FC_NONE);

  // R9: isolate is read/write without execute; no cache mode means no rights
  a_r9_isolate: assert property (@(posedge clk) disable iff (!rstN)
    cacheMode == CM_ISOLATE |-> (rdOk && wrOk && !exOk));
  a_r9_none_empty: assert property (@(posedge clk) disable iff (!rstN)
    cacheMode == CM_NONE |-> !(rdOk || wrOk || exOk));

endmodule

// File: rtl/rgn_xlate_unit.sv
module rgn_xlate_unit
  import rgn_xlate_pkg::*;
#(
  parameter int ADDR_W             = 32,
  parameter int REGION_BITS        = 3,
  parameter int FALLBACK_PAGE_LOG2 = 12
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              fallbackMode,
  input  logic [ADDR_W-1:0]                 reqVaddr,
  input  logic [1:0]                        reqKind,
  input  logic                              wrEn,
  input  logic                              wrTarget,
  input  logic [REGION_BITS-1:0]            wrIdx,
  input  logic [(4<<REGION_BITS)-1:0]       wrData,
  output logic [ADDR_W-1:0]                 physAddr,
  output logic [$clog2(ADDR_W+1)-1:0]       pageLog2,
  output logic                              rdOk,
  output logic                              wrOk,
  output logic                              exOk,
  output logic [2:0]                        cacheMode,
  output logic                              grant,
  output logic [1:0]                        faultCause
);

  ctlStrb_t strb;

  rgn_xlate_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .fallbackMode (fallbackMode),
    .reqKind      (reqKind),
    .wrEn         (wrEn),
    .wrTarget     (wrTarget),
    .strb         (strb)
  );

  rgn_xlate_dp #(
    .ADDR_W             (ADDR_W),
    .REGION_BITS        (REGION_BITS),
    .FALLBACK_PAGE_LOG2 (FALLBACK_PAGE_LOG2)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqVaddr   (reqVaddr),
    .wrIdx      (wrIdx),
    .wrData     (wrData),
    .physAddr   (physAddr),
    .pageLog2   (pageLog2),
    .rdOk       (rdOk),
    .wrOk       (wrOk),
    .exOk       (exOk),
    .cacheMode  (cacheMode),
    .grant      (grant),
    .faultCause (faultCause)
  );

endmodule

// File: tb/rgn_xlate_unit_tb.sv
module rgn_xlate_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fallbackMode = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqKind = '0;
  logic        wrEn = 1'b0;
  logic        wrTarget = 1'b0;
  logic [2:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic [31:0] physAddr;
  logic [5:0]  pageLog2;
  logic        rdOk, wrOk, exOk, grant;
  logic [2:0]  cacheMode;
  logic [1:0]  faultCause;

  int checks = 0;
  int fails  = 0;

  logic [2:0]  mBase [8];
  logic [3:0]  mAttr [8];
  logic [31:0] mCa;

  always #(CLK_PERIOD/2) clk = ~clk;

  rgn_xlate_unit u_dut (
    .clk(clk), .rstN(rstN), .fallbackMode(fallbackMode), .reqVaddr(reqVaddr),
    .reqKind(reqKind), .wrEn(wrEn), .wrTarget(wrTarget), .wrIdx(wrIdx), .wrData(wrData),
    .physAddr(physAddr), .pageLog2(pageLog2), .rdOk(rdOk), .wrOk(wrOk), .exOk(exOk),
    .cacheMode(cacheMode), .grant(grant), .faultCause(faultCause)
  );

  // {r,w,x,cacheMode}
  function automatic logic [5:0] expRights(input logic [3:0] a, input logic fb);
    case (a)
      4'd0:  return {3'b110, 3'd2};
      4'd1:  return {3'b111, 3'd2};
      4'd2:  return {3'b111, 3'd1};
      4'd3:  return {3'b001, 3'd3};
      4'd4:  return {3'b111, 3'd3};
      4'd5:  return fb ? 6'b000_000 : {3'b111, 3'd3};
      4'd14: return {3'b110, 3'd4};
      default: return 6'b000_000;
    endcase
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 8; i++) begin
      mBase[i] = 3'(i);
      mAttr[i] = 4'd2;
    end
    mCa = 32'h2222_2222;
  endtask

  task automatic step(input logic fb, input logic [31:0] va, input logic [1:0] kind,
                      input logic we, input logic tgt, input logic [2:0] idx,
                      input logic [31:0] data, input string tag);
    logic [2:0]  ri;
    logic [3:0]  at;
    logic [5:0]  er;
    logic [31:0] ePa;
    logic [5:0]  ePl;
    logic        eG;
    logic [1:0]  eC;
    @(negedge clk);
    fallbackMode = fb; reqVaddr = va; reqKind = kind;
    wrEn = we; wrTarget = tgt; wrIdx = idx; wrData = data;
    #1;
    ri  = va[31:29];
    at  = fb ? mCa[ri*4 +: 4] : mAttr[ri];
    er  = expRights(at, fb);
    ePa = fb ? va : {mBase[ri], va[28:0]};
    ePl = fb ? 6'd12 : 6'd29;
    eG  = (kind == 2'd0 && er[5]) || (kind == 2'd1 && er[4]) || (kind == 2'd2 && er[3]);
    eC  = eG ? 2'd0 : (kind == 2'd2 ? 2'd1 : (kind == 2'd1 ? 2'd3 : 2'd2));
    checks++;
    if (physAddr !== ePa || pageLog2 !== ePl || {rdOk, wrOk, exOk, cacheMode} !== er ||
        grant !== eG || faultCause !== eC) begin
      fails++;
      $display("FAIL %s: va=%h fb=%0d kind=%0d got pa=%h pl=%0d rwx/cm=%b g=%0d c=%0d exp pa=%h pl=%0d rwx/cm=%b g=%0d c=%0d",
               tag, va, fb, kind, physAddr, pageLog2, {rdOk, wrOk, exOk, cacheMode}, grant,
               faultCause, ePa, ePl, er, eG, eC);
    end
    @(posedge clk);
    if (we && rstN) begin
      if (tgt) mCa = data;
      else begin
        mBase[idx] = data[6:4];
        mAttr[idx] = data[3:0];
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not end, got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    // R1: outputs while held in reset and right after release
    step(1'b0, 32'hA123_4567, 2'd0, 1'b0, 1'b0, 3'd0, 32'd0, "R1 in reset");
    @(negedge clk); rstN = 1'b1;
    for (int r = 0; r < 8; r++)
      for (int k = 0; k < 3; k++) begin
        step(1'b0, {3'(r), 29'h0ABC_D12}, 2'(k), 1'b0, 1'b0, 3'd0, 32'd0, "R1 R2 translation reset");
        step(1'b1, {3'(r), 29'h1F00_0F0}, 2'(k), 1'b0, 1'b0, 3'd0, 32'd0, "R1 R5 fallback reset");
      end

    // R3 R4 R9 R6 R7: sweep every code in both modes through entry 3 and cacheAttr
    for (int a = 0; a < 16; a++) begin
      step(1'b0, 32'h0, 2'd0, 1'b1, 1'b0, 3'd3, {25'd0, 3'd6, 4'(a)}, "R8 entry write");
      step(1'b0, 32'h0, 2'd0, 1'b1, 1'b1, 3'd0, {8{4'(a)}}, "R8 cacheAttr write");
      for (int k = 0; k < 4; k++) begin
        step(1'b0, 32'h7FFF_FFFF, 2'(k), 1'b0, 1'b0, 3'd0, 32'd0, "R3 R6 R7 R9 translation decode");
        step(1'b1, 32'h6000_0010, 2'(k), 1'b0, 1'b0, 3'd0, 32'd0, "R4 R6 R7 R9 fallback decode");
      end
    end

    // R5: entries have no effect in fallback; distinct field per region
    step(1'b0, 32'h0, 2'd0, 1'b1, 1'b1, 3'd0, 32'hE543_210F, "R8 cacheAttr write");
    for (int r = 0; r < 8; r++)
      step(1'b1, {3'(r), 29'h0000_1234}, 2'd1, 1'b0, 1'b0, 3'd0, 32'd0, "R5 field select");

    // R8: write and same-region lookup in one cycle sees old value, then new
    step(1'b0, 32'hE000_0004, 2'd2, 1'b1, 1'b0, 3'd7, {25'd0, 3'd1, 4'd3}, "R8 same cycle old");
    step(1'b0, 32'hE000_0004, 2'd2, 1'b0, 1'b0, 3'd0, 32'd0, "R8 next cycle new");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] rv;
      rv = $urandom();
      step(rv[0], $urandom(), rv[2:1], rv[3] & rv[4], rv[5], rv[8:6],
           (rv[9] ? $urandom() : {25'd0, rv[12:10], rv[16:13]}), "R2 R3 R5 R7 R8 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule